// File: doc/BRIEF.md
# Auto-Reload Underflow Down Timer

This block is a 16-bit down-counting timer meant to sit on the byte-wide register bus of a small microcontroller. Software writes a reload value into two write-only bytes, then sets a count-enable bit. From then on the counter steps down by one on every tick of the selected source. When it steps past zero, it does not hold at FFFFh. It reloads itself from the preload bytes, and it may raise a sticky interrupt flag.

The tick comes from either a slow-clock pulse or a fast-clock pulse, and the operating clock mode decides which one. Both pulses are single-cycle enables in the system clock domain. Reset leaves the counter at zero, so the first tick after enabling wraps at once, raises the interrupt and loads the preload value. After that, the interval between interrupts is the preload value plus one ticks. The pending flag drives the interrupt controller and is cleared through a dedicated one-cycle input.

Top module: `rdt_timer`

## Requirements
- R1: After synchronous reset, `count_value` is 0000h, `irq_pending` is 0, and the count-enable and interrupt-enable bits are both 0.
- R2: The count enable is bit 2 of address 09h, and the interrupt enable is bit 2 of address 02h. Both are writable and read back on `bus_rdata` with every other bit reading 0. Written values for the other bits are ignored.
- R3: Address 03h holds the low preload byte and address 04h holds the high preload byte. Both are write-only, and reading them returns 00h.
- R4: While the count enable is 1 and the selected tick is 1, a nonzero count decreases by exactly one at that clock edge.
- R5: A tick that arrives while the count is 0000h is an underflow. It loads the 16-bit preload value instead of FFFFh. With preload N, consecutive underflows are N+1 ticks apart.
- R6: If the timer is enabled straight after reset, the first tick underflows. That tick loads the preload at once and sets `irq_pending` if interrupts are enabled.
- R7: `clk_mode` 0 (dual) and 1 (slow-only) count on `slow_tick`. Mode 2 (fast-only) counts on `fast_tick`. Mode 3 counts on neither.
- R8: While the count enable is 0, or no selected tick is present, the count holds its value.
- R9: Writing the preload bytes does not alter the running count. The new value is used only at the next underflow.
- R10: `irq_pending` is set by an underflow only while the interrupt enable is 1. The underflow and the reload still take place while the interrupt enable is 0.
- R11: A one-cycle `irq_clear` clears `irq_pending`. If an interrupt-enabled underflow occurs in the same cycle, the set takes priority.
- R12: A register write takes effect at the clock edge on which `bus_wr` is sampled. The count and the flag update at the edge on which the tick is sampled. The read path is combinational from `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| clk_mode | input | 2 | Operating clock mode: 0 dual, 1 slow-only, 2 fast-only, 3 none |
| slow_tick | input | 1 | Slow-clock tick pulse |
| fast_tick | input | 1 | Fast-clock tick pulse |
| irq_clear | input | 1 | Clears the pending interrupt flag |
| irq_pending | output | 1 | Sticky interrupt request |
| count_value | output | 16 | Current counter contents |

## Verification
Every stateful result is due one clock edge after its stimulus. A write changes the stored bit or byte at the edge that samples it. A tick changes `count_value` and `irq_pending` at that same edge, and a clear drops the flag one edge later. Read data is valid within the cycle in which the address is driven. The bench drives all inputs on the falling edge. A reference model, advanced at each rising edge from the bench's own copies of those inputs, computes the expected count and flag, and the bench compares them on the next falling edge. For that reason no check can land in the wrong cycle. The underflow period is measured as the distance between two flag rising edges, with the clear applied one cycle after each rise.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    localparam int CNT_W_DEF   = 16;
    localparam int DATA_W_DEF  = 8;
    localparam int ADDR_W_DEF  = 8;

    // register addresses; the preload bytes occupy consecutive addresses, low byte first
    localparam int ADR_IE      = 2;
    localparam int ADR_PL_BASE = 3;
    localparam int ADR_CTRL    = 9;
    localparam int CTRL_BIT    = 2;

    typedef enum logic [1:0] {
        CLK_DUAL = 2'd0,
        CLK_SLOW = 2'd1,
        CLK_FAST = 2'd2,
        CLK_NONE = 2'd3
    } clk_mode_e;

    typedef struct packed {
        logic cnt_en;
        logic irq_en;
    } tmr_ctrl_t;

    function automatic logic pick_tick(clk_mode_e m, logic slow_t, logic fast_t);
        case (m)
            CLK_DUAL, CLK_SLOW: return slow_t;
            CLK_FAST:           return fast_t;
            default:            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rdt_regs.sv
module rdt_regs
    import rdt_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output tmr_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  preload
);
    localparam int NBYTES = CNT_W / DATA_W;

    tmr_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADR_CTRL)) ctrl_q.cnt_en <= wdata[CTRL_BIT];
            if (addr == ADDR_W'(ADR_IE))   ctrl_q.irq_en <= wdata[CTRL_BIT];
        end
    end

    genvar i;
    generate
        for (i = 0; i < NBYTES; i++) begin : g_pl
            logic [DATA_W-1:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)
                    byte_q <= '0;
                else if (wr_en && addr == ADDR_W'(ADR_PL_BASE + i))
                    byte_q <= wdata;
            end
            assign preload[i*DATA_W +: DATA_W] = byte_q;
        end
    endgenerate

    // preload bytes are write-only and fall through to zero
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADR_IE))   rdata[CTRL_BIT] = ctrl_q.irq_en;
        if (addr == ADDR_W'(ADR_CTRL)) rdata[CTRL_BIT] = ctrl_q.cnt_en;
    end

    assign ctrl = ctrl_q;

    // R2: a write to the control address lands in the enable bit at the next edge
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(ADR_CTRL)) |=> (ctrl.cnt_en == $past(wdata[CTRL_BIT])));

    // R2: no write, no change of the enables
    a_r2_ctrl_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl));

endmodule

// File: rtl/rdt_tick_sel.sv
module rdt_tick_sel
    import rdt_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       slow_tick,
    input  logic       fast_tick,
    output logic       tick
);
    always_comb begin
        tick = pick_tick(clk_mode_e'(mode), slow_tick, fast_tick);
    end

    // R7: the reserved mode never passes a tick
    always_comb begin
        if (mode == 2'd3) a_r7_none_mode: assert (!tick);
    end

endmodule

// File: rtl/rdt_counter.sv
module rdt_counter #(
    parameter int CNT_W = rdt_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);
    logic step;

    assign step      = en && tick;
    assign underflow = step && (count == '0);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (step)
            count <= (count == '0) ? preload : count - 1'b1;
    end

    // R4: nonzero count steps down by one
    a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
        (step && count != '0) |=> (count == $past(count) - 1'b1));

    // R5: the wrap loads the preload value, never FFFFh by default
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (step && count == '0) |=> (count == $past(preload)));

    // R8: idle means hold
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(count));

endmodule

// File: rtl/rdt_timer.sv
module rdt_timer
    import rdt_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        clk_mode,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              irq_clear,
    output logic              irq_pending,
    output logic [CNT_W-1:0]  count_value
);
    tmr_ctrl_t        ctrl;
    logic [CNT_W-1:0] preload;
    logic             tick;
    logic             underflow;
    logic             irq_set;
    logic             pend_q;

    rdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr_en   (bus_wr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .ctrl    (ctrl),
        .preload (preload)
    );

    rdt_tick_sel u_tick (
        .mode      (clk_mode),
        .slow_tick (slow_tick),
        .fast_tick (fast_tick),
        .tick      (tick)
    );

    rdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.cnt_en),
        .tick      (tick),
        .preload   (preload),
        .count     (count_value),
        .underflow (underflow)
    );

    assign irq_set = underflow && ctrl.irq_en;

    // set has priority over clear
    always_ff @(posedge clk) begin
        if (rst)            pend_q <= 1'b0;
        else if (irq_set)   pend_q <= 1'b1;
        else if (irq_clear) pend_q <= 1'b0;
    end

    assign irq_pending = pend_q;

    // R10: an enabled underflow always leaves the flag set
    a_r10_set: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> irq_pending);

    // R10: the flag never rises without an enabled underflow
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!irq_pending && !(underflow && ctrl.irq_en)) |=> !irq_pending);

    // R11: clear drops the flag unless a set competes
    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        (irq_clear && !(underflow && ctrl.irq_en)) |=> !irq_pending);

endmodule

// File: tb/rdt_timer_bench.sv
`timescale 1ns/1ps
module rdt_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  clk_mode = 2'd2;
    logic        slow_tick = 1'b0;
    logic        fast_tick = 1'b0;
    logic        irq_clear = 1'b0;
    logic        irq_pending;
    logic [15:0] count_value;

    always #4 clk = ~clk;

    rdt_timer u_rdt_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_mode(clk_mode),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .irq_clear(irq_clear),
        .irq_pending(irq_pending), .count_value(count_value)
    );

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    string       cur_req = "R4";

    // reference model state
    logic        m_en, m_ie, m_pend;
    logic [15:0] m_pl, m_cnt;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic sel_tick(logic [1:0] m, logic s, logic f);
        if (m == 2'd0 || m == 2'd1) return s;
        if (m == 2'd2) return f;
        return 1'b0;
    endfunction

    task automatic model_step();
        logic t, uf;
        if (rst) begin
            m_en = 0; m_ie = 0; m_pend = 0; m_pl = '0; m_cnt = '0;
            return;
        end
        t  = sel_tick(clk_mode, slow_tick, fast_tick);
        uf = m_en && t && (m_cnt == 16'h0);
        if (m_en && t) m_cnt = uf ? m_pl : m_cnt - 16'd1;
        if (uf && m_ie)     m_pend = 1'b1;
        else if (irq_clear) m_pend = 1'b0;
        if (bus_wr) begin
            if (bus_addr == 8'h02) m_ie = bus_wdata[2];
            if (bus_addr == 8'h09) m_en = bus_wdata[2];
            if (bus_addr == 8'h03) m_pl[7:0]  = bus_wdata;
            if (bus_addr == 8'h04) m_pl[15:8] = bus_wdata;
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(count_value == m_cnt, cur_req, 32'(count_value), 32'(m_cnt));
        chk(irq_pending == m_pend, cur_req, 32'(irq_pending), 32'(m_pend));
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cycle();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, req, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic fticks(input int n);
        for (int k = 0; k < n; k++) begin
            fast_tick = 1'b1; cycle();
        end
        fast_tick = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1 reset state
        cur_req = "R1";
        rst = 1'b1;
        cycle(); cycle();
        rst = 1'b0;
        @(negedge clk);
        chk(count_value == 16'h0, "R1", 32'(count_value), 0);
        chk(irq_pending == 1'b0, "R1", 32'(irq_pending), 0);
        rd(8'h02, 8'h00, "R1");
        rd(8'h09, 8'h00, "R1");

        // R2 readback, only bit 2 stored
        cur_req = "R2";
        wr(8'h02, 8'hFF);
        rd(8'h02, 8'h04, "R2");
        wr(8'h09, 8'hFB);
        rd(8'h09, 8'h00, "R2");
        wr(8'h02, 8'h00);
        rd(8'h02, 8'h00, "R2");

        // R3 write-only preload bytes
        cur_req = "R3";
        wr(8'h03, 8'h07);
        wr(8'h04, 8'h00);
        rd(8'h03, 8'h00, "R3");
        rd(8'h04, 8'h00, "R3");

        // R6 first tick after reset reloads immediately
        cur_req = "R6";
        wr(8'h02, 8'h04);
        wr(8'h09, 8'h04);
        clk_mode = 2'd2;
        fticks(1);
        chk(count_value == 16'h0007, "R6", 32'(count_value), 7);
        chk(irq_pending == 1'b1, "R6", 32'(irq_pending), 1);

        // R11 clear, and set beats clear
        cur_req = "R11";
        irq_clear = 1'b1; cycle(); irq_clear = 1'b0;
        chk(irq_pending == 1'b0, "R11", 32'(irq_pending), 0);

        // R4 decrement
        cur_req = "R4";
        fticks(3);
        chk(count_value == 16'h0004, "R4", 32'(count_value), 4);

        // R9 preload rewrite leaves running count alone
        cur_req = "R9";
        wr(8'h03, 8'h02);
        chk(count_value == 16'h0004, "R9", 32'(count_value), 4);
        fticks(4);
        chk(count_value == 16'h0000, "R9", 32'(count_value), 0);
        fast_tick = 1'b1; irq_clear = 1'b1; cycle();
        fast_tick = 1'b0; irq_clear = 1'b0;
        chk(count_value == 16'h0002, "R9", 32'(count_value), 2);
        chk(irq_pending == 1'b1, "R11", 32'(irq_pending), 1);

        // R8 hold while disabled
        cur_req = "R8";
        wr(8'h09, 8'h00);
        fticks(5);
        chk(count_value == 16'h0002, "R8", 32'(count_value), 2);
        wr(8'h09, 8'h04);

        // R7 source selection
        cur_req = "R7";
        clk_mode = 2'd1; fticks(2);
        chk(count_value == 16'h0002, "R7", 32'(count_value), 2);
        clk_mode = 2'd0; slow_tick = 1'b1; cycle(); slow_tick = 1'b0;
        chk(count_value == 16'h0001, "R7", 32'(count_value), 1);
        clk_mode = 2'd3; slow_tick = 1'b1; fast_tick = 1'b1; cycle();
        slow_tick = 1'b0; fast_tick = 1'b0;
        chk(count_value == 16'h0001, "R7", 32'(count_value), 1);
        clk_mode = 2'd2;

        // R10 reload without flag when interrupt disabled
        cur_req = "R10";
        irq_clear = 1'b1; cycle(); irq_clear = 1'b0;
        wr(8'h02, 8'h00);
        fticks(2);
        chk(count_value == 16'h0002, "R10", 32'(count_value), 2);
        chk(irq_pending == 1'b0, "R10", 32'(irq_pending), 0);

        // R5 period N+1 with N=5
        cur_req = "R5";
        wr(8'h03, 8'h05);
        wr(8'h02, 8'h04);
        begin
            int  cyc = 0, last = -1, seen = 0;
            logic prev = 1'b0;
            fast_tick = 1'b1;
            for (int k = 0; k < 40; k++) begin
                irq_clear = irq_pending;
                cycle();
                cyc++;
                if (irq_pending && !prev) begin
                    if (last >= 0 && seen < 4) begin
                        chk(cyc - last == 6, "R5", 32'(cyc - last), 6);
                        seen++;
                    end
                    last = cyc;
                end
                prev = irq_pending;
            end
            fast_tick = 1'b0; irq_clear = 1'b0;
        end

        // R12 random mix against the model
        cur_req = "R12";
        for (int k = 0; k < 4000; k++) begin
            int unsigned r = $urandom_range(0, 7);
            bus_wr    = ($urandom_range(0, 5) == 0);
            bus_addr  = (r == 0) ? 8'h02 : (r == 1) ? 8'h09 : (r == 2) ? 8'h03 :
                        (r == 3) ? 8'h04 : 8'($urandom_range(0, 15));
            bus_wdata = (bus_addr == 8'h04) ? 8'($urandom_range(0, 1)) :
                        (bus_addr == 8'h09) ? 8'h04 : 8'($urandom);
            clk_mode  = 2'($urandom_range(0, 3));
            slow_tick = 1'($urandom);
            fast_tick = 1'($urandom);
            irq_clear = ($urandom_range(0, 3) == 0);
            cycle();
        end
        bus_wr = 1'b0; slow_tick = 1'b0; fast_tick = 1'b0; irq_clear = 1'b0;

        summary();
        $finish;
    end

endmodule